// File: doc/BRIEF.md
# Dual GPIO Port Register File

This block keeps the output latches and the pin direction settings for two general-purpose ports: a narrow port of 4 pins and a wide port of 8 pins. A processor reaches each port's data through its own address on a simple read/write register interface. Direction settings are not on that interface. Each port has its own load strobe that takes a direction value from a shared direction data bus. For every pin the block drives an output value and an output enable, and it takes back the pin level seen at the pad.

The processor's instruction cycle is marked by two phase inputs. `cyc_start` marks the first clock of the cycle and `cyc_end` marks the last. Data writes and direction loads take effect on the clock where `cyc_end` is high. Reads capture on the clock where `cyc_start` is high. A read returns the live pin level after a two-flop synchronizer. It never returns the output latch. A pin that is driven high while an outside source holds it low therefore reads as 0.

Reset is asserted asynchronously and released synchronously inside the block. Reset makes every pin an input and clears the read data register. It does not clear the output latches.

Top module: `gpio_dual_port`

## Requirements
- R1: While reset is held, and after it is released, every `pin_oe_*` bit is 0 and `rd_data` is 0x00, until a direction load or a read occurs.
- R2: A clock with `dir_ld_n` (or `dir_ld_w`) high and `cyc_end` high loads `dir_data[3:0]` (or `dir_data[7:0]`) into that port's direction register. A direction bit of 0 sets the matching `pin_oe_*` bit to 1 (output). A bit of 1 sets it to 0 (input). Each pin is set on its own. A load strobe on a clock without `cyc_end` changes nothing.
- R3: A clock with `wr_en` and `cyc_end` high updates one port's output latch. Address 0x05 writes `wr_data[3:0]` to the narrow latch and address 0x06 writes `wr_data[7:0]` to the wide latch. The new value shows on `pin_out_*` from the next clock.
- R4: A write on a clock without `cyc_end`, or a write to any address other than 0x05 or 0x06, leaves both latches unchanged.
- R5: An output latch holds its value until it is written again, including across direction changes. `pin_out_*` carries the latch whether or not the pin is enabled.
- R6: A clock with `rd_en` and `cyc_start` high captures the synchronized pin levels of the addressed port into `rd_data`. It never captures the latch. A pin driven 1 but held at 0 from outside reads as 0.
- R7: A read of address 0x05 returns the narrow pins in bits 3:0 and 0 in bits 7:4.
- R8: A read of any address other than 0x05 or 0x06 returns 0x00.
- R9: `rd_data` changes only on a read capture. It holds between reads, and `rd_en` without `cyc_start` does not update it.
- R10: When a write commit and a read capture of the same port fall on the same clock, the read returns the pin level from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | First clock of an instruction cycle (read sample point) |
| cyc_end | input | 1 | Last clock of an instruction cycle (write commit point) |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Data write request |
| wr_data | input | 8 | Data to write |
| rd_en | input | 1 | Data read request |
| rd_data | output | 8 | Captured pin levels of the last read |
| dir_ld_n | input | 1 | Direction load strobe, narrow port |
| dir_ld_w | input | 1 | Direction load strobe, wide port |
| dir_data | input | 8 | Direction value for the load strobes (1 = input) |
| pin_in_n | input | 4 | Pad levels, narrow port |
| pin_out_n | output | 4 | Output latch, narrow port |
| pin_oe_n | output | 4 | Output enable, narrow port |
| pin_in_w | input | 8 | Pad levels, wide port |
| pin_out_w | output | 8 | Output latch, wide port |
| pin_oe_w | output | 8 | Output enable, wide port |

## Verification
A write commit and a read capture can fall on the same clock when an instruction cycle is one clock long, with `cyc_start` and `cyc_end` both high. The bench provokes this with a combined write and read of one port, both directed and at random. The pins are first held stable for three clocks. The read is then judged against the pin level the bench model predicts from before the write. A normal read a few clocks later is judged against the new level, with an outside driver forcing chosen pins low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Which port a register access refers to
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_NARROW = 2'd1,
    SEL_WIDE   = 2'd2
  } port_sel_e;

  function automatic port_sel_e decode_addr(
    input logic [7:0] a,
    input logic [7:0] a_narrow,
    input logic [7:0] a_wide
  );
    if (a == a_narrow)    return SEL_NARROW;
    else if (a == a_wide) return SEL_WIDE;
    else                  return SEL_NONE;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int unsigned PW     = 4,
  parameter int unsigned BW     = 8,
  parameter logic [BW-1:0] ADDR = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end,
  input  logic          wr_en,
  input  logic [BW-1:0] addr,
  input  logic [BW-1:0] wr_data,
  input  logic          dir_ld,
  input  logic [BW-1:0] dir_data,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe
);
  logic [PW-1:0] latch_q;
  logic [PW-1:0] latch_d;
  logic          latch_en;
  logic [PW-1:0] dir_q;
  logic [PW-1:0] dir_d;
  logic          dir_en;

  // next-state
  always_comb begin
    latch_en = wr_en && cyc_end && (addr == ADDR);
    latch_d  = wr_data[PW-1:0];
    dir_en   = dir_ld && cyc_end;
    dir_d    = dir_data[PW-1:0];
  end

  // output latch: not reset, keeps its value until rewritten
  always_ff @(posedge clk) begin
    if (latch_en) latch_q <= latch_d;
  end

  // direction register: reset to all inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_en) dir_q <= dir_d;
  end

  assign pin_out = latch_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned WIDE_W   = 8,
  parameter int unsigned BUS_W    = 8,
  parameter logic [BUS_W-1:0] ADDR_NARROW = 8'h05,
  parameter logic [BUS_W-1:0] ADDR_WIDE   = 8'h06
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_start,
  input  logic                cyc_end,
  input  logic [BUS_W-1:0]    addr,
  input  logic                wr_en,
  input  logic [BUS_W-1:0]    wr_data,
  input  logic                rd_en,
  output logic [BUS_W-1:0]    rd_data,
  input  logic                dir_ld_n,
  input  logic                dir_ld_w,
  input  logic [BUS_W-1:0]    dir_data,
  input  logic [NARROW_W-1:0] pin_in_n,
  output logic [NARROW_W-1:0] pin_out_n,
  output logic [NARROW_W-1:0] pin_oe_n,
  input  logic [WIDE_W-1:0]   pin_in_w,
  output logic [WIDE_W-1:0]   pin_out_w,
  output logic [WIDE_W-1:0]   pin_oe_w
);
  import gpio_pkg::*;

  logic                rst_i_n;
  logic [NARROW_W-1:0] sync_n;
  logic [WIDE_W-1:0]   sync_w;
  port_sel_e           rd_sel;
  logic                rd_cap;
  logic [BUS_W-1:0]    rd_d;
  logic [BUS_W-1:0]    rd_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  gpio_port_slice #(.PW(NARROW_W), .BW(BUS_W), .ADDR(ADDR_NARROW)) u_narrow (
    .clk(clk), .rst_n(rst_i_n), .cyc_end(cyc_end), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .dir_ld(dir_ld_n), .dir_data(dir_data),
    .pin_out(pin_out_n), .pin_oe(pin_oe_n)
  );

  gpio_port_slice #(.PW(WIDE_W), .BW(BUS_W), .ADDR(ADDR_WIDE)) u_wide (
    .clk(clk), .rst_n(rst_i_n), .cyc_end(cyc_end), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .dir_ld(dir_ld_w), .dir_data(dir_data),
    .pin_out(pin_out_w), .pin_oe(pin_oe_w)
  );

  gpio_sync2 #(.W(NARROW_W)) u_sync_n (
    .clk(clk), .rst_n(rst_i_n), .d(pin_in_n), .q(sync_n)
  );

  gpio_sync2 #(.W(WIDE_W)) u_sync_w (
    .clk(clk), .rst_n(rst_i_n), .d(pin_in_w), .q(sync_w)
  );

  // next-state of the read register: sample at cycle start
  always_comb begin
    rd_sel = decode_addr(addr, ADDR_NARROW, ADDR_WIDE);
    rd_cap = rd_en && cyc_start;
    case (rd_sel)
      SEL_NARROW: rd_d = BUS_W'(sync_n);
      SEL_WIDE:   rd_d = BUS_W'(sync_w);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rd_q <= '0;
    else if (rd_cap) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk #(
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned WIDE_W   = 8,
  parameter int unsigned BUS_W    = 8,
  parameter logic [BUS_W-1:0] ADDR_NARROW = 8'h05,
  parameter logic [BUS_W-1:0] ADDR_WIDE   = 8'h06
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cyc_start,
  input logic                cyc_end,
  input logic [BUS_W-1:0]    addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [BUS_W-1:0]    rd_data,
  input logic                dir_ld_n,
  input logic                dir_ld_w,
  input logic [NARROW_W-1:0] pin_out_n,
  input logic [NARROW_W-1:0] pin_oe_n,
  input logic [WIDE_W-1:0]   pin_out_w,
  input logic [WIDE_W-1:0]   pin_oe_w
);
  // R2: enables move only after a committed direction load
  a_r2_oe_n_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe_n) |-> $past(dir_ld_n && cyc_end));
  a_r2_oe_w_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe_w) |-> $past(dir_ld_w && cyc_end));

  // R4: latches move only after a committed write to their own address
  a_r4_out_w_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out_w) |-> $past(wr_en && cyc_end && addr == ADDR_WIDE));
  a_r4_out_n_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out_n) |-> $past(wr_en && cyc_end && addr == ADDR_NARROW));

  // R7: narrow reads carry zeros above the port width
  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && cyc_start && addr == ADDR_NARROW) |-> rd_data[BUS_W-1:NARROW_W] == '0);

  // R8: unmapped reads return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && cyc_start && addr != ADDR_NARROW && addr != ADDR_WIDE) |-> rd_data == '0);

  // R9: read data holds between captures
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(rd_en && cyc_start));
endmodule

bind gpio_dual_port gpio_dual_port_chk #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .BUS_W(BUS_W),
  .ADDR_NARROW(ADDR_NARROW), .ADDR_WIDE(ADDR_WIDE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
  .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .dir_ld_n(dir_ld_n), .dir_ld_w(dir_ld_w),
  .pin_out_n(pin_out_n), .pin_oe_n(pin_oe_n),
  .pin_out_w(pin_out_w), .pin_oe_w(pin_oe_w)
);

// File: tb/gpio_dual_port_tb_top.sv
module gpio_dual_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, cyc_start, cyc_end, wr_en, rd_en, dir_ld_n, dir_ld_w;
  logic [7:0] addr, wr_data, rd_data, dir_data;
  logic [3:0] pin_in_n, pin_out_n, pin_oe_n;
  logic [7:0] pin_in_w, pin_out_w, pin_oe_w;

  // bench model state
  logic [7:0] m_lat_n, m_lat_w, m_dir_n, m_dir_w;
  logic [7:0] ext_n, ext_w, frc_n, frc_w;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // pad model: enabled pins drive the latch unless forced low; others follow ext
  assign pin_in_n = (pin_out_n & pin_oe_n & ~frc_n[3:0]) | (ext_n[3:0] & ~pin_oe_n);
  assign pin_in_w = (pin_out_w & pin_oe_w & ~frc_w) | (ext_w & ~pin_oe_w);

  gpio_dual_port dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .dir_ld_n(dir_ld_n), .dir_ld_w(dir_ld_w), .dir_data(dir_data),
    .pin_in_n(pin_in_n), .pin_out_n(pin_out_n), .pin_oe_n(pin_oe_n),
    .pin_in_w(pin_in_w), .pin_out_w(pin_out_w), .pin_oe_w(pin_oe_w)
  );

  function automatic logic [7:0] exp_pins(input logic [7:0] a);
    logic [7:0] t;
    if (a == 8'h05) begin
      t = (m_lat_n & ~m_dir_n & ~frc_n) | (ext_n & m_dir_n);
      return t & 8'h0F;
    end else if (a == 8'h06) begin
      return (m_lat_w & ~m_dir_w & ~frc_w) | (ext_w & m_dir_w);
    end
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check({tag, " out_n"}, {4'h0, pin_out_n}, m_lat_n & 8'h0F);
    check({tag, " oe_n"},  {4'h0, pin_oe_n},  ~m_dir_n & 8'h0F);
    check({tag, " out_w"}, pin_out_w, m_lat_w);
    check({tag, " oe_w"},  pin_oe_w,  ~m_dir_w);
  endtask

  task automatic idle_bus();
    cyc_start = 0; cyc_end = 0; wr_en = 0; rd_en = 0;
    dir_ld_n = 0; dir_ld_w = 0; addr = 0; wr_data = 0; dir_data = 0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit commit);
    addr = a; wr_data = d; wr_en = 1; cyc_end = commit;
    @(negedge clk);
    idle_bus();
    if (commit && a == 8'h05) m_lat_n = d & 8'h0F;
    if (commit && a == 8'h06) m_lat_w = d;
  endtask

  task automatic do_dir(input bit wide, input logic [7:0] d, input bit commit);
    dir_data = d; cyc_end = commit;
    if (wide) dir_ld_w = 1; else dir_ld_n = 1;
    @(negedge clk);
    idle_bus();
    if (commit && wide)  m_dir_w = d;
    if (commit && !wide) m_dir_n = d & 8'h0F;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] got);
    repeat (3) @(negedge clk);
    addr = a; rd_en = 1; cyc_start = 1;
    @(negedge clk);
    idle_bus();
    got = rd_data;
  endtask

  task automatic do_wr_rd(input logic [7:0] a, input logic [7:0] d, output logic [7:0] got);
    repeat (3) @(negedge clk);
    addr = a; wr_data = d; wr_en = 1; rd_en = 1; cyc_start = 1; cyc_end = 1;
    @(negedge clk);
    idle_bus();
    got = rd_data;
    if (a == 8'h05) m_lat_n = d & 8'h0F;
    if (a == 8'h06) m_lat_w = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, exp, prev, a, d;
    void'($urandom(32'd7351));
    idle_bus();
    ext_n = 0; ext_w = 0; frc_n = 0; frc_w = 0;
    m_dir_n = 8'h0F; m_dir_w = 8'hFF; m_lat_n = 0; m_lat_w = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 oe_n in reset", {4'h0, pin_oe_n}, 8'h00);
    check("R1 oe_w in reset", pin_oe_w, 8'h00);
    check("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 oe_w after release", pin_oe_w, 8'h00);
    check("R1 rd_data after release", rd_data, 8'h00);

    // R3: first writes set both latches
    do_write(8'h05, 8'hFA, 1);
    do_write(8'h06, 8'h5A, 1);
    check_pins("R3 first writes");

    // R4: no commit, wrong address
    do_write(8'h05, 8'h03, 0);
    check_pins("R4 write without cyc_end");
    do_write(8'h07, 8'hFF, 1);
    check_pins("R4 write to unmapped address");

    // R2: direction loads, per-pin
    do_dir(1, 8'h55, 1);
    check("R2 oe_w after 0x55", pin_oe_w, 8'hAA);
    do_dir(0, 8'h00, 0);
    check("R2 load without cyc_end", {4'h0, pin_oe_n}, 8'h00);

    // R5: latch survives direction changes
    do_dir(1, 8'hFF, 1);
    do_dir(1, 8'h00, 1);
    check("R5 latch kept over dir changes", pin_out_w, 8'h5A);

    // R6/R7: narrow read of input pins
    ext_n = 8'hFF;
    do_read(8'h05, got);
    check("R7 narrow read upper zero", got, 8'h0F);
    ext_w = 8'h00; frc_w = 8'h00;
    do_read(8'h06, got);
    check("R6 wide read of driven pins", got, 8'h5A);

    // R6: driven high, forced low externally; write then read
    do_dir(0, 8'h00, 1);
    frc_n = 8'h01;
    do_write(8'h05, 8'h0F, 1);
    do_read(8'h05, got);
    check("R6 forced pin reads low", got, 8'h0E);

    // R8
    do_read(8'h07, got);
    check("R8 read of 0x07", got, 8'h00);
    do_read(8'h00, got);
    check("R8 read of 0x00", got, 8'h00);

    // R9: hold between reads
    do_read(8'h06, got);
    prev = got;
    do_write(8'h06, 8'hC3, 1);
    repeat (4) @(negedge clk);
    check("R9 rd_data holds without read", rd_data, prev);
    addr = 8'h06; rd_en = 1;
    @(negedge clk);
    idle_bus();
    check("R9 rd_en without cyc_start", rd_data, prev);

    // R10: same-clock write commit and read capture
    frc_n = 8'h00;
    exp = exp_pins(8'h05);
    do_wr_rd(8'h05, 8'h06, got);
    check("R10 same clock read sees old level", got, exp);
    do_read(8'h05, got);
    check("R10 later read sees new level", got, exp_pins(8'h05));

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 5;
      a  = ($urandom % 2) ? 8'h06 : 8'h05;
      d  = 8'($urandom);
      case (op)
        0: do_write(a, d, ($urandom % 4) != 0);
        1: do_dir(a == 8'h06, d, ($urandom % 4) != 0);
        2: begin
          ext_n = 8'($urandom); ext_w = 8'($urandom);
          frc_n = 8'($urandom); frc_w = 8'($urandom);
          do_read(a, got);
          check("R6 random read", got, exp_pins(a));
        end
        3: begin
          exp = exp_pins(a);
          do_wr_rd(a, d, got);
          check("R10 random same clock", got, exp);
        end
        default: begin
          if (($urandom % 2) != 0) a = 8'($urandom);
          do_read(a, got);
          check("R8 random address read", got, exp_pins(a));
        end
      endcase
      check_pins("R5 random pins");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule